// File: doc/BRIEF.md
# Two-Stage Watchdog Timer Register Block

The block is a watchdog down-counter paired with a small register file on a simple synchronous register bus. The bus has an address, a write enable, two byte enables, 16-bit write data and combinational read data. Software programs a timeout period, reloads the counter by writing to its register, and halts or resumes it through a control bit. The counter advances only on cycles where the one-tick strobe input is high, so the tick rate is set outside the block. A tick is nominally 0.6 s, which makes a period of S seconds equal to S*10/6 ticks.

When the counter expires for the first time, the block sets a write-one-to-clear timeout flag, reloads itself from the period register and keeps counting. If software has not cleared that flag by the next expiry, the block escalates. It sets a second-timeout flag and a boot flag, and it pulses a reset request. The pulse is suppressed while the no-reboot input is high.

A sticky lock bit freezes the halt bit and the period register until the next hardware reset. Two further registers, a spare control word and a software-interrupt byte, are plain read/write storage.

Top module: `wdog_escalator`

## Requirements
- R1: After reset, reads return the following values. COUNT (address 0) reads 0, PERIOD (address 1) reads 4, STAT1 (address 2) reads 0, STAT2 (address 3) reads 0, CTRL1 (address 4) reads 0, CTRL2 (address 5) reads 0x0008 and SWIRQ (address 6) reads 0x03. The reset request output is low.
- R2: A write of any data to address 0 loads the counter from the effective period on that clock edge. A read of address 0 returns the live counter value, zero-extended.
- R3: On each tick, a running counter that is above 1 decreases by exactly one. A counter at 0 stays at 0 and never expires.
- R4: While CTRL1 bit 0 (halt) is 1, ticks leave the counter unchanged. Writing the bit back to 0 resumes counting.
- R5: After a reload with value V, the counter reads 1 after V-1 ticks and STAT1 bit 0 is still 0. The V-th tick sets STAT1 bit 0 and reloads the counter to V without a software write.
- R6: STAT1 bit 0 is write-one-to-clear. Writing 0 to it leaves it set, and writing back the value read clears it.
- R7: An expiry while STAT1 bit 0 is already set sets STAT2 bit 0 (second timeout) and STAT2 bit 1 (boot). Both bits are write-one-to-clear.
- R8: The reset request is high for exactly one cycle, the cycle after the edge of the escalating expiry. It stays low if the no-reboot input was high at that edge.
- R9: CTRL1 bit 1 (lock), once written to 1, reads 1 until hardware reset, whatever is written afterwards.
- R10: While the lock bit is set, writes to the halt bit and to PERIOD are ignored.
- R11: PERIOD keeps only its low CNT_W bits, so 0xFFFF reads back as 0x03FF at the default width. A stored period of 0 acts as 1.
- R12: CTRL2 (16 bits) and SWIRQ (8 bits) are read/write storage that honour the byte enables. Byte enable bit 0 covers data bits 7:0 and bit 1 covers data bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle count strobe |
| noReboot | input | 1 | Suppresses the reset request when high |
| busAddr | input | ADDR_W | Register address |
| busWrEn | input | 1 | Write enable |
| busByteEn | input | 2 | Byte enables for the write |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for busAddr (combinational) |
| rstReq | output | 1 | One-cycle reset request on second timeout |

## Verification
The bench builds the block with its default parameters: a 10-bit counter and a reset period of 4. With these values the largest period, 1023, can be counted all the way down within the run, so the step from 1 to expiry is checked at the top of the range. It also reaches the zero-period case and the second-timeout escalation under both settings of the no-reboot input. Ticks arrive every other clock, which keeps ticks separate from register writes so that lock, halt and reload effects can be tied to single edges.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned DATA_W = 16;

  typedef enum logic [2:0] {
    REG_COUNT  = 3'd0,
    REG_PERIOD = 3'd1,
    REG_STAT1  = 3'd2,
    REG_STAT2  = 3'd3,
    REG_CTRL1  = 3'd4,
    REG_CTRL2  = 3'd5,
    REG_SWIRQ  = 3'd6
  } regSel_e;

  localparam int unsigned HALT_BIT   = 0;
  localparam int unsigned LOCK_BIT   = 1;
  localparam int unsigned TO_BIT     = 0;
  localparam int unsigned SECOND_BIT = 0;
  localparam int unsigned BOOT_BIT   = 1;

  // strobes from control to datapath
  typedef struct packed {
    logic reload;
    logic run;
  } dpStrobe_t;

  function automatic logic [DATA_W-1:0] mergeBytes(
    input logic [DATA_W-1:0] oldVal,
    input logic [DATA_W-1:0] newVal,
    input logic [1:0]        be
  );
    mergeBytes = {be[1] ? newVal[15:8] : oldVal[15:8],
                  be[0] ? newVal[7:0]  : oldVal[7:0]};
  endfunction
endpackage

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] periodEff,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cntQ;
  logic             step;

  assign step   = tick && strobe.run && !strobe.reload && (cntQ != '0);
  assign expire = step && (cntQ == ONE);
  assign cnt    = cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobe.reload) begin
      cntQ <= periodEff;
    end else if (step) begin
      if (cntQ == ONE) cntQ <= periodEff;
      else             cntQ <= cntQ - ONE;
    end
  end

  // R3: one step per tick above 1
  p_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tick && strobe.run && !strobe.reload && cntQ > ONE) |=> (cntQ == $past(cntQ) - ONE));

  // R4: a halted counter holds
  p_halt_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.run && !strobe.reload) |=> $stable(cntQ));

  // R2: reload takes the effective period
  p_reload_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload |=> (cntQ == $past(periodEff)));

  // R5: expiry reloads automatically
  p_auto_reload_r5: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> (cntQ == $past(periodEff)));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned RST_PERIOD = 4,
  parameter logic [15:0] CTRL2_RST  = 16'h0008,
  parameter logic [7:0]  SWIRQ_RST  = 8'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              noReboot,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [1:0]        busByteEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              expire,
  output dpStrobe_t         strobe,
  output logic [CNT_W-1:0]  periodEff,
  output logic              rstReq
);
  localparam logic [CNT_W-1:0] PERIOD_RST = CNT_W'(RST_PERIOD);

  logic [CNT_W-1:0] periodQ;
  logic haltQ, lockQ, toFlagQ, secFlagQ, bootFlagQ, rstReqQ;
  logic [15:0] ctrl2Q;
  logic [7:0]  swirqQ;

  logic selCount, selPeriod, selStat1, selStat2, selCtrl1, selCtrl2, selSwirq;
  logic [DATA_W-1:0] ctrl1Rd, ctrl1New, periodNew, ctrl2New, swirqNew;
  logic clrTo, clrSec, clrBoot, escalate;

  assign selCount  = busWrEn && (busAddr == ADDR_W'(REG_COUNT));
  assign selPeriod = busWrEn && (busAddr == ADDR_W'(REG_PERIOD));
  assign selStat1  = busWrEn && (busAddr == ADDR_W'(REG_STAT1));
  assign selStat2  = busWrEn && (busAddr == ADDR_W'(REG_STAT2));
  assign selCtrl1  = busWrEn && (busAddr == ADDR_W'(REG_CTRL1));
  assign selCtrl2  = busWrEn && (busAddr == ADDR_W'(REG_CTRL2));
  assign selSwirq  = busWrEn && (busAddr == ADDR_W'(REG_SWIRQ));

  always_comb begin
    ctrl1Rd           = '0;
    ctrl1Rd[HALT_BIT] = haltQ;
    ctrl1Rd[LOCK_BIT] = lockQ;
  end

  assign ctrl1New  = mergeBytes(ctrl1Rd, busWrData, busByteEn);
  assign periodNew = mergeBytes(DATA_W'(periodQ), busWrData, busByteEn);
  assign ctrl2New  = mergeBytes(ctrl2Q, busWrData, busByteEn);
  assign swirqNew  = mergeBytes({8'h00, swirqQ}, busWrData, busByteEn);

  assign clrTo    = selStat1 && busByteEn[0] && busWrData[TO_BIT];
  assign clrSec   = selStat2 && busByteEn[0] && busWrData[SECOND_BIT];
  assign clrBoot  = selStat2 && busByteEn[0] && busWrData[BOOT_BIT];
  assign escalate = expire && toFlagQ;

  assign periodEff     = (periodQ == '0) ? CNT_W'(1) : periodQ;
  assign strobe.reload = selCount;
  assign strobe.run    = !haltQ;
  assign rstReq        = rstReqQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodQ   <= PERIOD_RST;
      haltQ     <= 1'b0;
      lockQ     <= 1'b0;
      toFlagQ   <= 1'b0;
      secFlagQ  <= 1'b0;
      bootFlagQ <= 1'b0;
      rstReqQ   <= 1'b0;
      ctrl2Q    <= CTRL2_RST;
      swirqQ    <= SWIRQ_RST;
    end else begin
      if (selPeriod && !lockQ) periodQ <= periodNew[CNT_W-1:0];
      if (selCtrl1) begin
        if (!lockQ)              haltQ <= ctrl1New[HALT_BIT];
        if (ctrl1New[LOCK_BIT])  lockQ <= 1'b1;
      end
      if (selCtrl2) ctrl2Q <= ctrl2New;
      if (selSwirq) swirqQ <= swirqNew[7:0];
      // a set on the same edge wins over a clear
      toFlagQ   <= expire   || (toFlagQ   && !clrTo);
      secFlagQ  <= escalate || (secFlagQ  && !clrSec);
      bootFlagQ <= escalate || (bootFlagQ && !clrBoot);
      rstReqQ   <= escalate && !noReboot;
    end
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_W'(REG_COUNT):  busRdData = DATA_W'(cnt);
      ADDR_W'(REG_PERIOD): busRdData = DATA_W'(periodQ);
      ADDR_W'(REG_STAT1):  busRdData[TO_BIT] = toFlagQ;
      ADDR_W'(REG_STAT2): begin
        busRdData[SECOND_BIT] = secFlagQ;
        busRdData[BOOT_BIT]   = bootFlagQ;
      end
      ADDR_W'(REG_CTRL1):  busRdData = ctrl1Rd;
      ADDR_W'(REG_CTRL2):  busRdData = ctrl2Q;
      ADDR_W'(REG_SWIRQ):  busRdData = {8'h00, swirqQ};
      default:             busRdData = '0;
    endcase
  end

  // R5: expiry raises the timeout flag
  p_expire_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> toFlagQ);

  // R7: an unserviced expiry escalates
  p_second_r7: assert property (@(posedge clk) disable iff (!rstN)
    (expire && toFlagQ) |=> (secFlagQ && bootFlagQ));

  // R8: reset request only when no-reboot was low
  p_rst_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    rstReqQ |-> $past(!noReboot));

  // R8: reset request lasts one cycle
  p_rst_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rstReqQ && !escalate) |=> !rstReqQ);

  // R9: lock is sticky
  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> lockQ);

  // R10: locked period and halt are frozen
  p_locked_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> ($stable(periodQ) && $stable(haltQ)));
endmodule

// File: rtl/wdog_escalator.sv
module wdog_escalator
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned RST_PERIOD = 4,
  parameter logic [15:0] CTRL2_RST  = 16'h0008,
  parameter logic [7:0]  SWIRQ_RST  = 8'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              noReboot,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [1:0]        busByteEn,
  input  logic [15:0]       busWrData,
  output logic [15:0]       busRdData,
  output logic              rstReq
);
  dpStrobe_t        strobe;
  logic [CNT_W-1:0] periodEff;
  logic [CNT_W-1:0] cnt;
  logic             expire;

  wdog_ctrl #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .RST_PERIOD(RST_PERIOD),
    .CTRL2_RST(CTRL2_RST), .SWIRQ_RST(SWIRQ_RST)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .noReboot(noReboot),
    .busAddr(busAddr), .busWrEn(busWrEn), .busByteEn(busByteEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .cnt(cnt), .expire(expire), .strobe(strobe),
    .periodEff(periodEff), .rstReq(rstReq)
  );

  wdog_dp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .tick(tick), .strobe(strobe),
    .periodEff(periodEff), .cnt(cnt), .expire(expire)
  );
endmodule

// File: tb/sim_wdog_escalator.sv
`timescale 1ns/1ps
module sim_wdog_escalator;
  localparam logic [2:0] A_COUNT = 3'd0, A_PERIOD = 3'd1, A_STAT1 = 3'd2,
                         A_STAT2 = 3'd3, A_CTRL1 = 3'd4, A_CTRL2 = 3'd5,
                         A_SWIRQ = 3'd6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic noReboot = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [1:0]  busByteEn = '0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic        rstReq;

  always #2.5 clk = ~clk;

  wdog_escalator u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .noReboot(noReboot),
    .busAddr(busAddr), .busWrEn(busWrEn), .busByteEn(busByteEn),
    .busWrData(busWrData), .busRdData(busRdData), .rstReq(rstReq)
  );

  typedef struct {
    bit          isRst;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t sbQ[$];
  bit pendReq = 1'b0;
  int total = 0;
  int bad = 0;

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (pendReq && sbQ.size() > 0) begin
        item_t it;
        logic [15:0] got;
        it  = sbQ.pop_front();
        got = it.isRst ? {15'b0, rstReq} : busRdData;
        total++;
        if (got !== it.exp) begin
          bad++;
          $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic chkRd(input logic [2:0] a, input logic [15:0] e, input string tag);
    item_t it;
    @(negedge clk);
    busAddr = a;
    it.isRst = 1'b0; it.exp = e; it.tag = tag;
    sbQ.push_back(it);
    pendReq = 1'b1;
    @(negedge clk);
    pendReq = 1'b0;
  endtask

  task automatic chkRst(input logic e, input string tag);
    item_t it;
    it.isRst = 1'b1; it.exp = {15'b0, e}; it.tag = tag;
    sbQ.push_back(it);
    pendReq = 1'b1;
    @(negedge clk);
    pendReq = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    busAddr = a; busWrData = d; busByteEn = be; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog: got hung expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    chkRst(1'b0, "R1 rstReq low");
    chkRd(A_COUNT,  16'h0000, "R1 count");
    chkRd(A_PERIOD, 16'h0004, "R1 period");
    chkRd(A_STAT1,  16'h0000, "R1 stat1");
    chkRd(A_STAT2,  16'h0000, "R1 stat2");
    chkRd(A_CTRL1,  16'h0000, "R1 ctrl1");
    chkRd(A_CTRL2,  16'h0008, "R1 ctrl2");
    chkRd(A_SWIRQ,  16'h0003, "R1 swirq");
    // R3 idle at zero
    ticks(3);
    chkRd(A_COUNT, 16'h0000, "R3 idle count");
    chkRd(A_STAT1, 16'h0000, "R3 idle no expiry");
    // R2 reload
    wr(A_PERIOD, 16'h0005, 2'b11);
    wr(A_COUNT, 16'hBEEF, 2'b11);
    chkRd(A_COUNT, 16'h0005, "R2 reload");
    ticks(2);
    chkRd(A_COUNT, 16'h0003, "R3 step");
    // R4 halt
    wr(A_CTRL1, 16'h0001, 2'b11);
    ticks(3);
    chkRd(A_COUNT, 16'h0003, "R4 halted");
    wr(A_CTRL1, 16'h0000, 2'b11);
    ticks(1);
    chkRd(A_COUNT, 16'h0002, "R4 resumed");
    // R5 expiry
    ticks(1);
    chkRd(A_COUNT, 16'h0001, "R5 at one");
    chkRd(A_STAT1, 16'h0000, "R5 no flag yet");
    ticks(1);
    chkRd(A_STAT1, 16'h0001, "R5 flag set");
    chkRd(A_COUNT, 16'h0005, "R5 auto reload");
    // R6 write-one-to-clear
    wr(A_STAT1, 16'h0000, 2'b11);
    chkRd(A_STAT1, 16'h0001, "R6 zero write keeps");
    wr(A_STAT1, 16'h0001, 2'b11);
    chkRd(A_STAT1, 16'h0000, "R6 cleared");
    // R7 / R8 escalation with reboot allowed
    ticks(5);
    chkRd(A_STAT1, 16'h0001, "R7 first expiry");
    chkRd(A_STAT2, 16'h0000, "R7 no second yet");
    ticks(5);
    chkRst(1'b1, "R8 reset pulse");
    chkRst(1'b0, "R8 pulse ends");
    chkRd(A_STAT2, 16'h0003, "R7 second and boot");
    wr(A_STAT2, 16'h0003, 2'b11);
    chkRd(A_STAT2, 16'h0000, "R7 stat2 cleared");
    // R8 no-reboot gate
    noReboot = 1'b1;
    ticks(5);
    chkRst(1'b0, "R8 gated by noReboot");
    chkRd(A_STAT2, 16'h0003, "R7 second again");
    wr(A_STAT2, 16'h0003, 2'b11);
    wr(A_STAT1, 16'h0001, 2'b11);
    // R11 zero period and masking
    wr(A_PERIOD, 16'h0000, 2'b11);
    chkRd(A_PERIOD, 16'h0000, "R11 period zero");
    wr(A_COUNT, 16'h0000, 2'b11);
    chkRd(A_COUNT, 16'h0001, "R11 zero acts as one");
    ticks(1);
    chkRd(A_STAT1, 16'h0001, "R11 expiry at one tick");
    wr(A_PERIOD, 16'hFFFF, 2'b11);
    chkRd(A_PERIOD, 16'h03FF, "R11 masked");
    wr(A_COUNT, 16'h0000, 2'b11);
    wr(A_STAT1, 16'h0001, 2'b11);
    ticks(1022);
    chkRd(A_COUNT, 16'h0001, "R5 max at one");
    chkRd(A_STAT1, 16'h0000, "R5 max no flag");
    ticks(1);
    chkRd(A_STAT1, 16'h0001, "R5 max flag");
    chkRd(A_COUNT, 16'h03FF, "R5 max reload");
    // R12 plain registers with byte enables
    wr(A_CTRL2, 16'hABCD, 2'b01);
    chkRd(A_CTRL2, 16'h00CD, "R12 ctrl2 low byte");
    wr(A_CTRL2, 16'h1234, 2'b10);
    chkRd(A_CTRL2, 16'h12CD, "R12 ctrl2 high byte");
    wr(A_SWIRQ, 16'h125A, 2'b11);
    chkRd(A_SWIRQ, 16'h005A, "R12 swirq");
    // R9 / R10 lock
    wr(A_CTRL1, 16'h0002, 2'b11);
    chkRd(A_CTRL1, 16'h0002, "R9 lock set");
    wr(A_CTRL1, 16'h0000, 2'b11);
    chkRd(A_CTRL1, 16'h0002, "R9 lock sticky");
    wr(A_CTRL1, 16'h0003, 2'b11);
    chkRd(A_CTRL1, 16'h0002, "R10 halt ignored");
    wr(A_PERIOD, 16'h0007, 2'b11);
    chkRd(A_PERIOD, 16'h03FF, "R10 period ignored");
    wr(A_COUNT, 16'h0000, 2'b11);
    ticks(1);
    chkRd(A_COUNT, 16'h03FE, "R10 still running");
    repeat (3) @(negedge clk);
    if (sbQ.size() != 0) begin
      bad++;
      $display("FAIL scoreboard: got %0d left expected 0", sbQ.size());
    end
    summary();
    $finish;
  end
endmodule